// File: doc/BRIEF.md
# Soft-edged slow PWM controller

This block switches a heater load with a slow pulse-width modulation whose edges are softened. Turning the load on or off never happens in one step. The output is walked up or down through a series of fast PWM periods whose duty grows or shrinks in even steps. Between ramps the output sits fully low or fully high for a whole number of slow periods. This keeps the switch quiet without holding it in its linear region for long.

Inside sit an 8-bit free-running timer with a two-way prescaler and a compare unit that drives the pin. The prescaler divides by 1 for the fast ramp periods and by `PRE_DIV` (default 8) for the steady periods. With the defaults, a fast period is 256 clocks and a slow period is 2048 clocks. A sequencer advances once per timer overflow. It accumulates a programmable step into an 8-bit wrapping slow counter. It compares that counter with a duty value taken from a 7-bit request. The prescaler, compare level, output polarity and an optional reload of the timer count change only at an overflow, so each change takes effect at a period boundary.

A temperature loop upstream sets the duty request. It sets the step value to tune the length of the slow cycle.

Top module: `softedge_pwm`

## Requirements
- R1: After reset, `heat_pin` is low. It stays low for as long as `en` is low.
- R2: With `en` high and `duty_req` = 0, `heat_pin` never goes high.
- R3: A rise consists of 15 fast periods of 256 clocks. In step j (j = 1..15), the pin is high for 16·j clocks and then low for 256 − 16·j clocks. After step 15 the pin stays low for 16 clocks and then starts the full-high plateau.
- R4: The duty value d is 2·`duty_req`. While the machine is low, the slow counter s is updated once per slow period to s = (s + `step_inc`) mod 256. The low hold continues while the new s is greater than d. The first update with s ≤ d starts a rise one slow period later. The low gap from the end of a fall to the next rise is therefore 251 + 2048·m clocks, where m is the number of updates made in the low hold.
- R5: While the machine is high, the slow counter is updated the same way. The plateau ends at the first update whose new value is greater than d. The plateau is 251 + 2048·(k − 1) clocks of continuous high, where k is the number of updates in the high hold. A new value equal to d keeps the output high.
- R6: A fall follows the plateau. In step j (j = 1..14) the pin is low for 16·j clocks and then high for 240 − 16·j clocks. After the last step the pin stays low.
- R7: With `step_inc` held fixed and starting from reset, the high time of a slow cycle does not decrease as `duty_req` increases.
- R8: When `en` is low at a clock edge, `heat_pin` is low after that edge. The sequencer and the slow counter return to their reset state.
- R9: The pin rises only in the clock that follows a timer overflow. The prescaler selection changes only at an overflow or when `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable. Low forces the output off and returns the sequencer to its reset state |
| duty_req | input | 7 | Duty request. The internal duty value is this request shifted left by one |
| step_inc | input | 8 | Amount added to the slow counter each slow period |
| heat_pin | output | 1 | Drive for the heater switch |

## Verification
The pin is combinational from the timer and compare registers. Each register update therefore shows at the pin right after the clock edge that makes it. The bench drives and samples only at falling edges. It checks `en` going low at the first falling edge after the edge that sees it.

Ramp steps, plateaus and low gaps are measured as run lengths counted in clocks. This makes them independent of where the first overflow falls after enable. Each expected run length comes from R3 to R6. The values k and m are derived in the bench by stepping the wrapping slow counter from zero, both for directed duty/step pairs (including the s = d boundary) and for random ones.

// File: rtl/softedge_pkg.sv
package softedge_pkg;

    localparam int CNT_W      = 8;
    localparam int REQ_W      = CNT_W - 1;
    localparam int RAMP_STEPS = 16;
    localparam int RAMP_W     = $clog2(RAMP_STEPS);
    localparam int STEP_SHIFT = CNT_W - RAMP_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [RAMP_W-1:0] ramp_t;

    localparam cnt_t  CNT_FULL  = '1;
    localparam cnt_t  CNT_NEAR  = CNT_FULL - cnt_t'(1);
    localparam cnt_t  CNT_ZERO  = '0;
    localparam ramp_t RAMP_LAST = ramp_t'(RAMP_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_UP_PREP,
        ST_UP,
        ST_UP_DONE,
        ST_HIGH,
        ST_DOWN,
        ST_DOWN_DONE
    } seq_state_t;

    // Settings for the timer period that starts at the next overflow.
    typedef struct packed {
        logic load_en;
        cnt_t load_val;
        logic fast;
        cnt_t cmp;
        logic invert;
    } period_setup_t;

    function automatic period_setup_t mk_setup(input logic load_en, input cnt_t load_val,
                                               input logic fast, input cnt_t cmp,
                                               input logic invert);
        period_setup_t s;
        s.load_en  = load_en;
        s.load_val = load_val;
        s.fast     = fast;
        s.cmp      = cmp;
        s.invert   = invert;
        return s;
    endfunction

    // Output held off: slow prescaler, inverted polarity, full compare.
    function automatic period_setup_t idle_setup();
        return mk_setup(1'b0, CNT_ZERO, 1'b0, CNT_FULL, 1'b1);
    endfunction

    // Rising compare level for a ramp count r in 1..RAMP_STEPS-1.
    function automatic cnt_t up_level(input ramp_t r);
        logic [RAMP_W:0] steps;
        steps = (RAMP_W + 1)'(RAMP_STEPS) - {1'b0, r};
        return cnt_t'(steps) << STEP_SHIFT;
    endfunction

    // Falling compare level for a ramp count r in 1..RAMP_STEPS-1.
    function automatic cnt_t down_level(input ramp_t r);
        return cnt_t'(r) << STEP_SHIFT;
    endfunction

    // High from bottom until the match; full compare keeps it high all period.
    function automatic logic pin_level(input cnt_t cnt, input cnt_t cmp, input logic invert);
        logic on;
        on = (cnt < cmp) || (cmp == CNT_FULL);
        return on ^ invert;
    endfunction

endpackage

// File: rtl/softedge_timebase.sv
module softedge_timebase
    import softedge_pkg::*;
#(
    parameter int PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic apply_i,
    input  logic fast_i,
    input  logic load_en_i,
    input  cnt_t load_val_i,
    output cnt_t cnt_o,
    output logic ovf_o,
    output logic fast_o
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    cnt_t             cnt_q;
    logic             fast_q;
    logic             tick;
    logic             ovf;

    generate
        if (PRE_DIV > 1) begin : g_div
            assign tick = fast_q | (pre_q == PRE_LAST);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    assign ovf = tick && (cnt_q == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            fast_q <= 1'b0;
        end else begin
            if (tick || apply_i) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
            if (tick) begin
                if (ovf) begin
                    cnt_q <= load_en_i ? load_val_i : CNT_ZERO;
                end else begin
                    cnt_q <= cnt_q + cnt_t'(1);
                end
            end
            if (apply_i) begin
                fast_q <= fast_i;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign ovf_o  = ovf;
    assign fast_o = fast_q;

endmodule

// File: rtl/softedge_compare.sv
module softedge_compare
    import softedge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic apply_i,
    input  cnt_t cmp_i,
    input  logic invert_i,
    input  cnt_t cnt_i,
    output logic pin_o
);

    cnt_t cmp_q;
    logic invert_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= CNT_FULL;
            invert_q <= 1'b1;
        end else if (apply_i) begin
            cmp_q    <= cmp_i;
            invert_q <= invert_i;
        end
    end

    assign pin_o = pin_level(cnt_i, cmp_q, invert_q);

endmodule

// File: rtl/softedge_sequencer.sv
module softedge_sequencer
    import softedge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             ovf_i,
    input  logic [REQ_W-1:0] req_i,
    input  cnt_t             inc_i,
    output period_setup_t    setup_o,
    output logic             apply_o,
    output seq_state_t       state_o,
    output ramp_t            ramp_o
);

    seq_state_t    state_q, state_d;
    cnt_t          slow_q, slow_d;
    cnt_t          duty_q, duty_d;
    ramp_t         ramp_q, ramp_d;
    period_setup_t setup;
    cnt_t          req_duty;
    cnt_t          slow_sum;

    assign req_duty = cnt_t'({req_i, 1'b0});
    assign slow_sum = slow_q + inc_i;

    always_comb begin
        state_d = state_q;
        slow_d  = slow_q;
        duty_d  = duty_q;
        ramp_d  = ramp_q;
        setup   = idle_setup();
        unique case (state_q)
            ST_IDLE: begin
                duty_d = req_duty;
                if (req_duty != CNT_ZERO) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                slow_d = slow_sum;
                duty_d = req_duty;
                if (req_duty == CNT_ZERO) begin
                    state_d = ST_IDLE;
                end else if (slow_sum <= duty_q) begin
                    state_d = ST_UP_PREP;
                end
            end
            ST_UP_PREP: begin
                setup   = mk_setup(1'b1, CNT_FULL, 1'b1, CNT_ZERO, 1'b0);
                ramp_d  = RAMP_LAST;
                state_d = ST_UP;
            end
            ST_UP: begin
                if (ramp_q != '0) begin
                    setup  = mk_setup(1'b0, CNT_ZERO, 1'b1, up_level(ramp_q), 1'b0);
                    ramp_d = ramp_q - ramp_t'(1);
                end else begin
                    setup   = mk_setup(1'b1, CNT_NEAR, 1'b1, CNT_FULL, 1'b0);
                    state_d = ST_UP_DONE;
                end
            end
            ST_UP_DONE: begin
                setup   = mk_setup(1'b1, CNT_FULL, 1'b0, CNT_FULL, 1'b0);
                state_d = ST_HIGH;
            end
            ST_HIGH: begin
                slow_d = slow_sum;
                if (slow_sum > duty_q) begin
                    setup   = mk_setup(1'b1, CNT_FULL, 1'b1, CNT_FULL, 1'b0);
                    ramp_d  = RAMP_LAST;
                    state_d = ST_DOWN;
                end else begin
                    setup = mk_setup(1'b0, CNT_ZERO, 1'b0, CNT_FULL, 1'b0);
                end
            end
            ST_DOWN: begin
                if (ramp_q != '0) begin
                    setup  = mk_setup(1'b0, CNT_ZERO, 1'b1, down_level(ramp_q), 1'b0);
                    ramp_d = ramp_q - ramp_t'(1);
                end else begin
                    setup   = mk_setup(1'b1, CNT_NEAR, 1'b1, CNT_ZERO, 1'b0);
                    state_d = ST_DOWN_DONE;
                end
            end
            ST_DOWN_DONE: begin
                setup   = mk_setup(1'b1, CNT_FULL, 1'b0, CNT_FULL, 1'b1);
                state_d = ST_LOW;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= ST_IDLE;
            slow_q  <= '0;
            duty_q  <= '0;
            ramp_q  <= '0;
        end else if (ovf_i) begin
            state_q <= state_d;
            slow_q  <= slow_d;
            duty_q  <= duty_d;
            ramp_q  <= ramp_d;
        end
    end

    assign setup_o = en_i ? setup : idle_setup();
    assign apply_o = ovf_i | ~en_i;
    assign state_o = state_q;
    assign ramp_o  = ramp_q;

endmodule

// File: rtl/softedge_pwm.sv
module softedge_pwm
    import softedge_pkg::*;
#(
    parameter int PRE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [REQ_W-1:0] duty_req,
    input  logic [CNT_W-1:0] step_inc,
    output logic             heat_pin
);

    period_setup_t setup;
    logic          apply;
    logic          ovf;
    logic          fast_sel;
    cnt_t          tcount;
    seq_state_t    seq_state;
    ramp_t         ramp_cnt;

    softedge_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .ovf_i   (ovf),
        .req_i   (duty_req),
        .inc_i   (step_inc),
        .setup_o (setup),
        .apply_o (apply),
        .state_o (seq_state),
        .ramp_o  (ramp_cnt)
    );

    softedge_timebase #(
        .PRE_DIV (PRE_DIV)
    ) u_time (
        .clk        (clk),
        .rst        (rst),
        .apply_i    (apply),
        .fast_i     (setup.fast),
        .load_en_i  (setup.load_en),
        .load_val_i (setup.load_val),
        .cnt_o      (tcount),
        .ovf_o      (ovf),
        .fast_o     (fast_sel)
    );

    softedge_compare u_cmp (
        .clk      (clk),
        .rst      (rst),
        .apply_i  (apply),
        .cmp_i    (setup.cmp),
        .invert_i (setup.invert),
        .cnt_i    (tcount),
        .pin_o    (heat_pin)
    );

endmodule

// File: rtl/softedge_pwm_chk.sv
module softedge_pwm_chk
    import softedge_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       pin,
    input logic       ovf,
    input logic       fast,
    input seq_state_t state
);

    // R9: the pin goes high only at the start of a timer period
    p_rise_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(pin) |-> $past(ovf));

    // R9: the prescaler selection moves only at an overflow or on disable
    p_rate_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(fast) |-> ($past(ovf) || !$past(en)));

    // R8: disable drives the pin low after the edge
    p_disable_low_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pin);

    // R2: the idle sequencer state keeps the pin low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pin);

    // R4: the low hold never jumps straight into a ramp step
    p_low_not_up_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW) |=> (state != ST_UP));

    // R3: rise steps run on the undivided timer clock
    p_up_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UP) |-> fast);

    // R5: the high hold keeps the pin high
    p_high_full_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH) |-> pin);

endmodule

bind softedge_pwm softedge_pwm_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .pin   (heat_pin),
    .ovf   (ovf),
    .fast  (fast_sel),
    .state (seq_state)
);

// File: tb/softedge_pwm_test.sv
module softedge_pwm_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [6:0] duty_req = '0;
    logic [7:0] step_inc = '0;
    logic       heat_pin;

    int n_chk = 0;
    int n_fail = 0;

    softedge_pwm uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .duty_req (duty_req),
        .step_inc (step_inc),
        .heat_pin (heat_pin)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts falling edges on which the pin holds lvl.
    task automatic measure(input logic lvl, output int len);
        len = 0;
        while (heat_pin === lvl) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_high();
        while (heat_pin !== 1'b1) @(negedge clk);
    endtask

    // Slow-counter walk from zero per R4 and R5: low updates until the first
    // new value <= d, high updates until the first new value > d, then low
    // updates again until the first new value <= d.
    task automatic plan(input int d, input int inc, output int first, output int k, output int m);
        int s;
        s = 0;
        first = 0;
        do begin s = (s + inc) & 255; first++; end while (s > d && first < 64);
        k = 0;
        do begin s = (s + inc) & 255; k++; end while (s <= d && k < 64);
        m = 0;
        do begin s = (s + inc) & 255; m++; end while (s > d && m < 64);
    endtask

    task automatic start(input int req, input int inc);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        rst      = 1'b0;
        duty_req = 7'(req);
        step_inc = 8'(inc);
        en       = 1'b1;
    endtask

    task automatic run_cycle(input int req, input int inc, output int plat);
        int first, k, m, h, l;
        plan(2 * req, inc, first, k, m);
        start(req, inc);
        wait_high();
        for (int j = 1; j <= 15; j++) begin
            measure(1'b1, h);
            check(h == 16 * j, "R3 rise step high", h, 16 * j);
            measure(1'b0, l);
            check(l == ((j < 15) ? 256 - 16 * j : 16), "R3 rise step low", l,
                  (j < 15) ? 256 - 16 * j : 16);
        end
        measure(1'b1, plat);
        check(plat == 251 + 2048 * (k - 1), "R5 plateau length", plat, 251 + 2048 * (k - 1));
        for (int j = 1; j <= 14; j++) begin
            measure(1'b0, l);
            check(l == 16 * j, "R6 fall step low", l, 16 * j);
            measure(1'b1, h);
            check(h == 240 - 16 * j, "R6 fall step high", h, 240 - 16 * j);
        end
        measure(1'b0, l);
        check(l == 251 + 2048 * m, "R4 low hold gap", l, 251 + 2048 * m);
        en = 1'b0;
    endtask

    initial begin
        int p1, p2, p3, hc, r;
        void'($urandom(32'd4242));

        // R1: reset state and disabled output
        repeat (3) @(negedge clk);
        check(heat_pin === 1'b0, "R1 pin in reset", int'(heat_pin), 0);
        rst = 1'b0;
        hc = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (heat_pin === 1'b1) hc++;
        end
        check(hc == 0, "R1 pin while disabled", hc, 0);

        // R2: zero request
        start(0, 64);
        hc = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (heat_pin === 1'b1) hc++;
        end
        check(hc == 0, "R2 zero duty high clocks", hc, 0);

        // R8: disable during the first rise step
        start(40, 64);
        wait_high();
        repeat (5) @(negedge clk);
        check(heat_pin === 1'b1, "R8 pin high before disable", int'(heat_pin), 1);
        en = 1'b0;
        @(negedge clk);
        check(heat_pin === 1'b0, "R8 pin low after disable", int'(heat_pin), 0);
        hc = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (heat_pin === 1'b1) hc++;
        end
        check(hc == 0, "R8 pin stays low", hc, 0);

        // R7: rising request with a fixed step
        run_cycle(10, 64, p1);
        run_cycle(40, 64, p2);
        run_cycle(80, 64, p3);
        check(p2 >= p1, "R7 high time 20 vs 80", p2, p1);
        check(p3 >= p2, "R7 high time 80 vs 160", p3, p2);
        check(p3 > p1, "R7 high time 20 vs 160", p3, p1);

        // R5 boundary: new counter value equal to the duty keeps the output high
        run_cycle(64, 64, p1);
        // R4 boundary: wrap of the counter below the duty starts the rise
        run_cycle(63, 128, p1);

        // Random request and step
        r = 0;
        while (r < 1) begin
            int rq, ic, f, k, m;
            rq = 1 + int'($urandom % 127);
            ic = 48 + int'($urandom % 96);
            plan(2 * rq, ic, f, k, m);
            if (f < 64 && k < 64 && m < 64 && (2048 * (f + k + m) + 10300) <= 28000) begin
                run_cycle(rq, ic, p1);
                r++;
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (198000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R3 run did not complete actual=198000 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule